// File: doc/BRIEF.md
# Display Bridge Control Target on I2C

This block is an I2C target that presents the small control register space of a video transmitter bridge to a host controller. A host writes a register pointer as the first byte of a write transfer. It then reads or writes bytes in a burst, and the pointer steps forward after every byte. Three registers carry meaning. The identity register always reads as a fixed byte. The presence register reports an attached display with no pending plug event. The link-control register carries a request/grant handshake. When the host sets both the request and grant bits there, the block enters pass-through mode and raises a mode output. Downstream logic uses this output to route the bus to the display's configuration memory.

SCL and SDA are sampled on the system clock through a synchronizer chain. START, repeated START and STOP are recovered from the synchronized lines. SDA is driven open-drain through an active-high pull-down enable.

Top module: `xbridge_i2c_regs`

## Requirements
- R1: Synchronous reset clears the register pointer to 0x00, the pointer-load flag, the request flag and pass-through mode, and releases SDA.
- R2: The target acknowledges (pulls SDA low in the ninth clock) an address byte whose upper seven bits equal TARGET_ADDR and acknowledges every data byte written to it. Any other address gets no acknowledge, and the target stays idle until the next START.
- R3: The first data byte after a START with the write bit (bit 0 = 0) loads the register pointer and is not applied as register data.
- R4: The pointer increases by one after each data byte written or read, at any register address.
- R5: Writing register 0x1A with bit 2 set latches the request flag. If bit 1 is also set in the same byte, pass-through mode (mode output high) becomes active. Otherwise pass-through mode keeps its value.
- R6: Writing register 0x1A with bit 2 clear clears both the request flag and pass-through mode.
- R7: Reading register 0x1A returns 0x06 while the request flag is set and 0x00 otherwise.
- R8: Reading register 0x1B returns 0xB0.
- R9: Reading register 0x3D returns 0x04.
- R10: Reading any other register returns 0x00. A write to any register other than 0x1A is acknowledged and changes no readback value or output.
- R11: A repeated START with the read bit (bit 0 = 1) keeps the current pointer, so reading starts at the address written just before.
- R12: During a read, the target releases SDA after the eighth data bit. Once the controller answers with NACK (SDA high in the ninth clock), the target leaves SDA released until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples SCL and SDA |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_pull_o | output | 1 | High to pull SDA low (open-drain drive) |
| passthru_o | output | 1 | High while pass-through mode is active |

## Verification
The bench builds the block with its default parameters: TARGET_ADDR of 0x39 and a two-stage synchronizer. With these values the bench can address the target directly, and it can also send a foreign address (0x20) to confirm the target stays silent. The SCL half-period is twenty system clocks, well above the synchronizer and edge-detect latency. This lets the bench sample every acknowledge and read bit in the middle of the SCL high phase. The transfers cover pointer setup, bursts across 0x1A/0x1B, repeated START reads and reset in the middle of a session.

// File: rtl/xbr_pkg.sv
package xbr_pkg;

    // register addresses whose behaviour is decoded
    localparam logic [7:0] REG_LINKCTL = 8'h1A;
    localparam logic [7:0] REG_IDENT   = 8'h1B;
    localparam logic [7:0] REG_SENSE   = 8'h3D;

    // bit positions inside the link-control byte
    localparam int LC_REQ_BIT   = 2;
    localparam int LC_GRANT_BIT = 1;

    localparam logic [7:0] IDENT_VALUE  = 8'hB0;
    localparam logic [7:0] SENSE_VALUE  = 8'h04;
    localparam logic [7:0] LINK_GRANTED = 8'h06;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_ADDR_ACK,
        LK_WR,
        LK_WR_ACK,
        LK_RD,
        LK_RD_ACK
    } link_state_e;

    // byte-level events passed from the bus engine to the register file
    typedef struct packed {
        logic       sel_write;  // address matched with write bit
        logic       wr_stb;     // a data byte was received
        logic       rd_done;    // a data byte was shifted out
        logic [7:0] data;
    } link_evt_t;

    typedef struct packed {
        logic req;
        logic pt;
    } link_ctl_t;

    function automatic logic [7:0] reg_readback(input logic [7:0] ptr, input logic req);
        logic [7:0] v;
        v = 8'h00;
        case (ptr)
            REG_LINKCTL: v = req ? LINK_GRANTED : 8'h00;
            REG_IDENT:   v = IDENT_VALUE;
            REG_SENSE:   v = SENSE_VALUE;
            default:     v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic link_ctl_t linkctl_update(input link_ctl_t cur, input logic [7:0] wdata);
        link_ctl_t n;
        n = cur;
        if (wdata[LC_REQ_BIT]) begin
            n.req = 1'b1;
            if (wdata[LC_GRANT_BIT]) n.pt = 1'b1;
        end else begin
            n.req = 1'b0;
            n.pt  = 1'b0;
        end
        return n;
    endfunction

endpackage

// File: rtl/xbr_sync.sv
module xbr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic              scl_q, sda_q;

    assign raw = {scl_raw, sda_raw};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    assign scl_s = synced[1];
    assign sda_s = synced[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/xbr_link.sv
module xbr_link
    import xbr_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h39
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sda_s,
    input  logic        scl_rise,
    input  logic        scl_fall,
    input  logic        start_det,
    input  logic        stop_det,
    input  logic [7:0]  rd_data,
    output link_evt_t   evt,
    output logic        sda_pull
);
    link_state_e state;
    logic [2:0]  bitcnt;
    logic [7:0]  shreg;
    logic        full;
    logic        rw;
    logic        mack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= LK_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            full     <= 1'b0;
            rw       <= 1'b0;
            mack     <= 1'b0;
            sda_pull <= 1'b0;
            evt      <= '0;
        end else begin
            evt.sel_write <= 1'b0;
            evt.wr_stb    <= 1'b0;
            evt.rd_done   <= 1'b0;
            if (start_det) begin
                state    <= LK_ADDR;
                bitcnt   <= '0;
                full     <= 1'b0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                state    <= LK_IDLE;
                full     <= 1'b0;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    LK_ADDR, LK_WR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) full <= 1'b1;
                        end
                        if (scl_fall && full) begin
                            full <= 1'b0;
                            if (state == LK_ADDR) begin
                                if (shreg[7:1] == TARGET_ADDR) begin
                                    state         <= LK_ADDR_ACK;
                                    sda_pull      <= 1'b1;
                                    rw            <= shreg[0];
                                    evt.sel_write <= ~shreg[0];
                                end else begin
                                    state <= LK_IDLE;
                                end
                            end else begin
                                evt.wr_stb <= 1'b1;
                                evt.data   <= shreg;
                                state      <= LK_WR_ACK;
                                sda_pull   <= 1'b1;
                            end
                        end
                    end
                    LK_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                state    <= LK_RD;
                                shreg    <= rd_data;
                                sda_pull <= ~rd_data[7];
                            end else begin
                                state    <= LK_WR;
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    LK_WR_ACK: begin
                        if (scl_fall) begin
                            state    <= LK_WR;
                            bitcnt   <= '0;
                            sda_pull <= 1'b0;
                        end
                    end
                    LK_RD: begin
                        if (scl_fall) begin
                            if (bitcnt == 3'd7) begin
                                sda_pull    <= 1'b0;
                                state       <= LK_RD_ACK;
                                evt.rd_done <= 1'b1;
                                bitcnt      <= '0;
                            end else begin
                                shreg    <= {shreg[6:0], 1'b0};
                                sda_pull <= ~shreg[6];
                                bitcnt   <= bitcnt + 3'd1;
                            end
                        end
                    end
                    LK_RD_ACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        if (scl_fall) begin
                            if (mack) begin
                                state    <= LK_RD;
                                shreg    <= rd_data;
                                sda_pull <= ~rd_data[7];
                                bitcnt   <= '0;
                            end else begin
                                state <= LK_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/xbr_regfile.sv
module xbr_regfile
    import xbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  link_evt_t  evt,
    output logic [7:0] rd_data,
    output logic       passthru,
    output logic [7:0] ptr,
    output logic       ptr_load
);
    link_ctl_t ctl;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            ptr_load <= 1'b0;
            ctl      <= '0;
        end else begin
            if (evt.sel_write) begin
                ptr_load <= 1'b1;
            end else if (evt.wr_stb) begin
                if (ptr_load) begin
                    ptr      <= evt.data;
                    ptr_load <= 1'b0;
                end else begin
                    if (ptr == REG_LINKCTL) ctl <= linkctl_update(ctl, evt.data);
                    ptr <= ptr + 8'd1;
                end
            end else if (evt.rd_done) begin
                ptr <= ptr + 8'd1;
            end
        end
    end

    assign rd_data  = reg_readback(ptr, ctl.req);
    assign passthru = ctl.pt;

endmodule

// File: rtl/xbridge_i2c_regs.sv
module xbridge_i2c_regs
    import xbr_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h39,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o,
    output logic passthru_o
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    link_evt_t  evt;
    logic [7:0] rd_data;
    logic [7:0] ptr;
    logic       ptr_load;

    xbr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_raw   (scl_i),
        .sda_raw   (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    xbr_link #(.TARGET_ADDR(TARGET_ADDR)) u_link (
        .clk       (clk),
        .rst       (rst),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .evt       (evt),
        .sda_pull  (sda_pull_o)
    );

    xbr_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .rd_data  (rd_data),
        .passthru (passthru_o),
        .ptr      (ptr),
        .ptr_load (ptr_load)
    );

endmodule

// File: rtl/xbridge_i2c_regs_chk.sv
module xbridge_i2c_regs_chk
    import xbr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_s,
    input logic       sda_pull_o,
    input logic       passthru_o,
    input link_evt_t  evt,
    input logic [7:0] ptr,
    input logic       ptr_load
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_d) begin
            reset_state_chk: assert (!passthru_o && !sda_pull_o && ptr == 8'h00 && !ptr_load);
        end
    end

    // R12
    pull_only_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !scl_s);

    // R4
    read_step_chk: assert property (@(posedge clk) disable iff (rst)
        evt.rd_done |=> ptr == $past(ptr) + 8'd1);

    // R3
    ptr_byte_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.wr_stb && ptr_load) |=> ($stable(passthru_o) && ptr == $past(evt.data)));

    // R5
    grant_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(passthru_o) |-> $past(evt.wr_stb && !ptr_load && ptr == REG_LINKCTL
                                    && evt.data[LC_REQ_BIT] && evt.data[LC_GRANT_BIT]));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.wr_stb && !ptr_load && ptr == REG_LINKCTL && !evt.data[LC_REQ_BIT]) |=> !passthru_o);

endmodule

bind xbridge_i2c_regs xbridge_i2c_regs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_s      (scl_s),
    .sda_pull_o (sda_pull_o),
    .passthru_o (passthru_o),
    .evt        (evt),
    .ptr        (ptr),
    .ptr_load   (ptr_load)
);

// File: tb/xbridge_i2c_regs_test.sv
`timescale 1ns/1ps
module xbridge_i2c_regs_test;
    localparam logic [6:0] DEV = 7'h39;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull, passthru;
    wire  sda_line = sda_m & ~sda_pull;

    int total = 0;
    int bad = 0;
    logic [7:0] rbuf [0:3];
    logic ack_seen;

    always #4 clk = ~clk;

    xbridge_i2c_regs uut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .passthru_o (passthru)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wt(Q);
        scl = 1'b1;   wt(Q);
        sda_m = 1'b0; wt(Q);
        scl = 1'b0;   wt(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wt(Q);
        scl = 1'b1;   wt(Q);
        sda_m = 1'b1; wt(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(Q);
            scl = 1'b1;   wt(2*Q);
            scl = 1'b0;   wt(Q);
        end
        sda_m = 1'b1; wt(Q);
        scl = 1'b1;   wt(Q);
        acked = ~sda_line;
        wt(Q);
        scl = 1'b0;   wt(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(Q);
            scl = 1'b1; wt(Q);
            b[i] = sda_line;
            wt(Q);
            scl = 1'b0; wt(Q);
        end
        sda_m = ~give_ack; wt(Q);
        scl = 1'b1; wt(2*Q);
        scl = 1'b0; wt(Q);
        sda_m = 1'b1;
    endtask

    // write pointer, then n data bytes
    task automatic wr_regs(input logic [7:0] p, input logic [7:0] d0, input logic [7:0] d1, input int n);
        logic a;
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(p, a);
        if (n > 0) send_byte(d0, a);
        if (n > 1) send_byte(d1, a);
        bus_stop;
    endtask

    // pointer write, repeated start, read n bytes
    task automatic rd_regs(input logic [7:0] p, input int n);
        logic a;
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(p, a);
        bus_start;
        send_byte({DEV, 1'b1}, a);
        for (int i = 0; i < n; i++) recv_byte(i != n-1, rbuf[i]);
        bus_stop;
    endtask

    task automatic rd_here(input int n);
        logic a;
        bus_start;
        send_byte({DEV, 1'b1}, a);
        for (int i = 0; i < n; i++) recv_byte(i != n-1, rbuf[i]);
        bus_stop;
    endtask

    task automatic t_reset;
        chk("R1 passthru after reset", {7'd0, passthru}, 8'h00);
        chk("R1 sda released", {7'd0, sda_pull}, 8'h00);
        rd_here(1);
        chk("R1 pointer starts at 0", rbuf[0], 8'h00);
    endtask

    task automatic t_address;
        logic a;
        bus_start;
        send_byte({DEV, 1'b0}, a);
        chk("R2 own address acked", {7'd0, a}, 8'h01);
        send_byte(8'h20, a);
        chk("R2 pointer byte acked", {7'd0, a}, 8'h01);
        send_byte(8'h55, a);
        chk("R2 data byte acked", {7'd0, a}, 8'h01);
        bus_stop;
        bus_start;
        send_byte({7'h20, 1'b0}, a);
        chk("R2 foreign address not acked", {7'd0, a}, 8'h00);
        send_byte(8'h1A, a);
        chk("R2 foreign data not acked", {7'd0, a}, 8'h00);
        bus_stop;
    endtask

    task automatic t_pointer_write;
        // R3: pointer byte 0x06 must not act as link-control data
        wr_regs(8'h1A, 8'h00, 8'h00, 0);
        wr_regs(8'h06, 8'h00, 8'h00, 0);
        chk("R3 pointer byte inert", {7'd0, passthru}, 8'h00);
        // R4: 0x19 then two bytes, the second lands on 0x1A
        wr_regs(8'h19, 8'h06, 8'h06, 2);
        chk("R4 write auto-increment", {7'd0, passthru}, 8'h01);
        rd_regs(8'h1A, 3);
        chk("R4 read burst 0x1A", rbuf[0], 8'h06);
        chk("R4 read burst 0x1B", rbuf[1], 8'hB0);
        chk("R4 read burst 0x1C", rbuf[2], 8'h00);
        wr_regs(8'h1A, 8'h00, 8'h00, 1);
    endtask

    task automatic t_handshake;
        wr_regs(8'h1A, 8'h04, 8'h00, 1);
        chk("R5 request only keeps mode low", {7'd0, passthru}, 8'h00);
        rd_regs(8'h1A, 1);
        chk("R7 request reads 0x06", rbuf[0], 8'h06);
        wr_regs(8'h1A, 8'h06, 8'h00, 1);
        chk("R5 request+grant sets mode", {7'd0, passthru}, 8'h01);
        wr_regs(8'h1A, 8'h04, 8'h00, 1);
        chk("R5 request only keeps mode high", {7'd0, passthru}, 8'h01);
        wr_regs(8'h1A, 8'h02, 8'h00, 1);
        chk("R6 bit2 clear drops mode", {7'd0, passthru}, 8'h00);
        rd_regs(8'h1A, 1);
        chk("R7 cleared reads 0x00", rbuf[0], 8'h00);
    endtask

    task automatic t_fixed;
        rd_regs(8'h1B, 1);
        chk("R8 identity", rbuf[0], 8'hB0);
        rd_regs(8'h3D, 1);
        chk("R9 presence", rbuf[0], 8'h04);
        rd_regs(8'h3C, 3);
        chk("R10 other reg 0x3C", rbuf[0], 8'h00);
        chk("R9 presence in burst", rbuf[1], 8'h04);
        chk("R10 other reg 0x3E", rbuf[2], 8'h00);
        wr_regs(8'h1B, 8'h12, 8'h34, 2);
        wr_regs(8'h40, 8'hFF, 8'h00, 1);
        rd_regs(8'h1B, 1);
        chk("R10 write to identity ignored", rbuf[0], 8'hB0);
        rd_regs(8'h3D, 1);
        chk("R10 write to presence ignored", rbuf[0], 8'h04);
        rd_regs(8'h40, 1);
        chk("R10 write to 0x40 ignored", rbuf[0], 8'h00);
        chk("R10 mode untouched", {7'd0, passthru}, 8'h00);
    endtask

    task automatic t_rstart;
        wr_regs(8'h3D, 8'h00, 8'h00, 0);
        rd_here(1);
        chk("R11 read at written pointer", rbuf[0], 8'h04);
        rd_here(1);
        chk("R11 pointer advanced after read", rbuf[0], 8'h00);
    endtask

    task automatic t_nack;
        logic a;
        logic [7:0] b;
        logic seen;
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h1B, a);
        bus_start;
        send_byte({DEV, 1'b1}, a);
        recv_byte(1'b0, b);
        chk("R12 byte before NACK", b, 8'hB0);
        chk("R12 released after NACK", {7'd0, sda_pull}, 8'h00);
        seen = 1'b0;
        sda_m = 1'b1;
        for (int k = 0; k < 9; k++) begin
            wt(Q); scl = 1'b1; wt(Q);
            if (sda_pull) seen = 1'b1;
            wt(Q); scl = 1'b0; wt(Q);
            if (sda_pull) seen = 1'b1;
        end
        chk("R12 silent until next START", {7'd0, seen}, 8'h00);
        bus_stop;
    endtask

    task automatic t_reset_midway;
        wr_regs(8'h1A, 8'h06, 8'h00, 1);
        wr_regs(8'h1B, 8'h00, 8'h00, 0);
        wt(4);
        rst = 1'b1; wt(3); rst = 1'b0; wt(4);
        chk("R1 reset clears mode", {7'd0, passthru}, 8'h00);
        rd_here(1);
        chk("R1 reset clears pointer", rbuf[0], 8'h00);
        rd_regs(8'h1A, 1);
        chk("R1 reset clears request", rbuf[0], 8'h00);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wt(5);
        rst = 1'b0;
        wt(5);
        t_reset;
        t_address;
        t_pointer_write;
        t_handshake;
        t_fixed;
        t_rstart;
        t_nack;
        t_reset_midway;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule